// File: doc/BRIEF.md
# Three-Phase Complementary PWM Generator with Dead Time

This block drives three half-bridge legs (U, V, W). Each leg has a positive-side output and a negative-side output. The two outputs of a leg are never active at the same time. A gap of a programmable number of clocks, the dead time, separates every hand-over between them. All three legs share one 16-bit counter. The counter rises from the dead-time value to a programmable top and then falls back, forming a symmetric triangle. A leg's raw drive is high while the counter is above that leg's compare value.

Compare values are double-buffered. Software writes a staging register for a leg at any time. A two-bit transfer mode decides whether the staged values move into the live compare registers at the crest, at the trough, at both, or never. A second address per leg loads the live compare register at once.

While the run enable is low, the counter waits at the dead-time value. The outputs then take a start-up state chosen from where the live compare value lies relative to the dead time. Two level-select inputs choose active-high or active-low drive for the positive side and the negative side separately.

Top module: `pwm3_comp`

## Requirements
- R1: While `run` is low the counter holds the value of `dead_time`. While `run` is high it steps by exactly one every clock. It counts up to `period_top`, then down to `dead_time`, then up again. The step taken on the clock where the counter sits at `period_top` is the first step down.
- R2: A write with `wr_addr[2]`=0 updates only the staging register of leg `wr_addr[1:0]` (0=U, 1=V, 2=W). The live compare value, and so the outputs, stay unchanged until a transfer point selected by the mode.
- R3: `xfer_mode` selects the transfer point. 2'b00 copies staging to live on the crest clock, where the counter is at `period_top` while rising. 2'b01 copies on the trough clock, where the counter is at `dead_time` while falling. 2'b10 copies on both. 2'b11 never copies.
- R4: A write with `wr_addr[2]`=1 loads both the live compare value and the staging register of leg `wr_addr[1:0]` at that clock. It takes priority over a transfer on the same clock.
- R5: While running, the raw drive of a leg is high when the counter is strictly greater than its compare value. The positive output follows a high raw drive and the negative output follows a low raw drive. After every change of the raw drive, the newly selected output stays inactive for `dead_time` clocks.
- R6: The positive and negative outputs of a leg are never both active.
- R7: While running, when one output of a leg goes inactive and the other then goes active, the number of clocks between the two events equals `dead_time`.
- R8: While `run` is low, each leg takes a start-up state one clock after its compare value is seen. With a compare value of 0, positive is active and negative is inactive. With a value of at least 1 and at most `dead_time`, both outputs are inactive. With a value above `dead_time`, positive is inactive and negative is active.
- R9: With `pol_pos`=1, an active positive output is driven 1. With `pol_pos`=0, every positive level is inverted. `pol_neg` does the same for the negative outputs.
- R10: While `rst` is high, every output is at its inactive level, and the live and staging registers are cleared to 0.
- R11: A write whose leg field `wr_addr[1:0]` is 3 changes no register and no output.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| run | input | 1 | Counter run enable |
| xfer_mode | input | 2 | Staging-to-live transfer point selector |
| period_top | input | 16 | Counter crest value |
| dead_time | input | 16 | Dead time in clocks; also the counter trough |
| pol_pos | input | 1 | Level select for the positive outputs (1 = active high) |
| pol_neg | input | 1 | Level select for the negative outputs (1 = active high) |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 3 | Bit 2: immediate load; bits 1:0: leg |
| wr_data | input | 16 | Write data |
| out_pos | output | 3 | Positive outputs, bit 0 = U, bit 1 = V, bit 2 = W |
| out_neg | output | 3 | Negative outputs, bit 0 = U, bit 1 = V, bit 2 = W |

## Verification
The outputs are registered. A change in the counter or in a compare value therefore shows on the pins one clock later. An immediate write reaches the pins two clocks after it is driven: one clock to load the compare register and one to register the outputs. A staged value reaches the pins one clock after the crest or trough clock that transfers it. The start-up state follows a compare change while idle with the same two-clock lag. The bench's reference model applies these delays edge by edge from the inputs sampled on each rising edge. Outputs are compared on the following falling edge, so each result is read in the exact cycle it is due. The dead-time gaps are measured from the pins themselves, against the dead time sampled on the same edge.

// File: rtl/pwm3_pkg.sv
package pwm3_pkg;
  // Transfer point selector for staged compare values
  typedef enum logic [1:0] {
    XFER_CREST  = 2'b00,
    XFER_TROUGH = 2'b01,
    XFER_BOTH   = 2'b10,
    XFER_HOLD   = 2'b11
  } xfer_mode_e;
endpackage

// File: rtl/pwm_tri_counter.sv
// Symmetric up/down counter between the dead-time value and the top (R1)
module pwm_tri_counter #(
  parameter int W = 16
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         run,
  input  logic [W-1:0] td,
  input  logic [W-1:0] top,
  output logic [W-1:0] cnt,
  output logic         crest,
  output logic         trough
);
  logic up_q;

  assign crest  = run &  up_q & (cnt >= top);
  assign trough = run & ~up_q & (cnt <= td);

  always_ff @(posedge clk) begin
    if (rst || !run) begin
      cnt  <= td;
      up_q <= 1'b1;
    end else if (up_q) begin
      if (cnt >= top) begin
        up_q <= 1'b0;
        cnt  <= cnt - 1'b1;
      end else begin
        cnt  <= cnt + 1'b1;
      end
    end else begin
      if (cnt <= td) begin
        up_q <= 1'b1;
        cnt  <= cnt + 1'b1;
      end else begin
        cnt  <= cnt - 1'b1;
      end
    end
  end
endmodule

// File: rtl/pwm_cmp_bank.sv
// Staging and live compare registers per leg (R2, R3, R4, R11)
module pwm_cmp_bank
  import pwm3_pkg::*;
#(
  parameter int W      = 16,
  parameter int PHASES = 3,
  parameter int SEL_W  = 2
) (
  input  logic                         clk,
  input  logic                         rst,
  input  logic                         wr_en,
  input  logic [SEL_W:0]               wr_addr,
  input  logic [W-1:0]                 wr_data,
  input  xfer_mode_e                   mode,
  input  logic                         crest,
  input  logic                         trough,
  output logic [PHASES-1:0][W-1:0]     cmp
);
  logic xfer;

  always_comb begin
    case (mode)
      XFER_CREST:  xfer = crest;
      XFER_TROUGH: xfer = trough;
      XFER_BOTH:   xfer = crest | trough;
      default:     xfer = 1'b0;
    endcase
  end

  for (genvar p = 0; p < PHASES; p++) begin : g_leg
    logic [W-1:0] stage_q;
    logic [W-1:0] live_q;
    logic         sel;
    logic         hit_stage;
    logic         hit_now;

    assign sel       = wr_en && (wr_addr[SEL_W-1:0] == SEL_W'(p));
    assign hit_stage = sel && !wr_addr[SEL_W];
    assign hit_now   = sel &&  wr_addr[SEL_W];
    assign cmp[p]    = live_q;

    always_ff @(posedge clk) begin
      if (rst) begin
        stage_q <= '0;
        live_q  <= '0;
      end else if (hit_now) begin
        stage_q <= wr_data;
        live_q  <= wr_data;
      end else begin
        if (xfer)      live_q  <= stage_q;
        if (hit_stage) stage_q <= wr_data;
      end
    end
  end
endmodule

// File: rtl/pwm_deadband.sv
// One leg: raw compare drive, dead-time delay, start-up state, level select
// (R5, R8, R9, R10)
module pwm_deadband #(
  parameter int W = 16
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         run,
  input  logic [W-1:0] cnt,
  input  logic [W-1:0] cmp,
  input  logic [W-1:0] td,
  input  logic         pol_p,
  input  logic         pol_n,
  output logic         out_p,
  output logic         out_n
);
  localparam logic [W-1:0] SAT = '1;

  logic         side_q, side_d;
  logic [W-1:0] age_q, age_d;
  logic         raw;
  logic         settled;
  logic         act_p, act_n;

  always_comb begin
    raw = (cnt > cmp);
    if (!run) begin
      side_d = (cmp == '0);
      age_d  = ((cmp == '0) || (cmp > td)) ? SAT : '0;
    end else if (raw != side_q) begin
      side_d = raw;
      age_d  = '0;
    end else begin
      side_d = side_q;
      age_d  = (age_q == SAT) ? age_q : age_q + 1'b1;
    end
    settled = (age_d >= td);
    act_p   =  side_d & settled;
    act_n   = ~side_d & settled;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      side_q <= 1'b0;
      age_q  <= '0;
      out_p  <= ~pol_p;
      out_n  <= ~pol_n;
    end else begin
      side_q <= side_d;
      age_q  <= age_d;
      out_p  <= pol_p ? act_p : ~act_p;
      out_n  <= pol_n ? act_n : ~act_n;
    end
  end
endmodule

// File: rtl/pwm3_comp.sv
module pwm3_comp
  import pwm3_pkg::*;
#(
  parameter int W      = 16,
  parameter int PHASES = 3,
  parameter int SEL_W  = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              run,
  input  logic [1:0]        xfer_mode,
  input  logic [W-1:0]      period_top,
  input  logic [W-1:0]      dead_time,
  input  logic              pol_pos,
  input  logic              pol_neg,
  input  logic              wr_en,
  input  logic [SEL_W:0]    wr_addr,
  input  logic [W-1:0]      wr_data,
  output logic [PHASES-1:0] out_pos,
  output logic [PHASES-1:0] out_neg
);
  logic [W-1:0]             cnt;
  logic                     crest;
  logic                     trough;
  logic [PHASES-1:0][W-1:0] cmp_q;

  pwm_tri_counter #(.W(W)) u_cnt (
    .clk(clk), .rst(rst), .run(run), .td(dead_time), .top(period_top),
    .cnt(cnt), .crest(crest), .trough(trough)
  );

  pwm_cmp_bank #(.W(W), .PHASES(PHASES), .SEL_W(SEL_W)) u_bank (
    .clk(clk), .rst(rst), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .mode(xfer_mode_e'(xfer_mode)), .crest(crest), .trough(trough), .cmp(cmp_q)
  );

  for (genvar p = 0; p < PHASES; p++) begin : g_leg
    pwm_deadband #(.W(W)) u_db (
      .clk(clk), .rst(rst), .run(run), .cnt(cnt), .cmp(cmp_q[p]),
      .td(dead_time), .pol_p(pol_pos), .pol_n(pol_neg),
      .out_p(out_pos[p]), .out_n(out_neg[p])
    );
  end
endmodule

// File: rtl/pwm3_comp_chk.sv
module pwm3_comp_chk #(
  parameter int W      = 16,
  parameter int PHASES = 3,
  parameter int SEL_W  = 2
) (
  input logic                     clk,
  input logic                     rst,
  input logic                     run,
  input logic [1:0]               xfer_mode,
  input logic [W-1:0]             dead_time,
  input logic                     pol_pos,
  input logic                     pol_neg,
  input logic                     wr_en,
  input logic [SEL_W:0]           wr_addr,
  input logic [W-1:0]             wr_data,
  input logic [W-1:0]             cnt,
  input logic [PHASES-1:0][W-1:0] cmp,
  input logic [PHASES-1:0]        out_pos,
  input logic [PHASES-1:0]        out_neg
);
  // R1: idle counter parks at the dead-time value
  p_idle_park_r1: assert property (@(posedge clk) disable iff (rst)
    !run |=> (cnt == $past(dead_time)));

  // R1: running counter moves by exactly one per clock
  p_unit_step_r1: assert property (@(posedge clk) disable iff (rst)
    run |=> ((cnt == $past(cnt) + 1'b1) || (cnt == $past(cnt) - 1'b1)));

  // R3: hold mode leaves live compare values alone without an immediate write
  p_hold_mode_r3: assert property (@(posedge clk) disable iff (rst)
    (xfer_mode == 2'b11 && !(wr_en && wr_addr[SEL_W])) |=> $stable(cmp));

  // R4: immediate write to leg 0 lands in its live register next clock
  p_imm_load_r4: assert property (@(posedge clk) disable iff (rst)
    (wr_en && wr_addr == {1'b1, {SEL_W{1'b0}}}) |=> (cmp[0] == $past(wr_data)));

  // R8: idle leg 0 with zero compare drives positive active, negative inactive
  p_idle_zero_r8: assert property (@(posedge clk) disable iff (rst)
    (!run && cmp[0] == '0) |=>
      (out_pos[0] == $past(pol_pos) && out_neg[0] != $past(pol_neg)));

  // R10: reset forces inactive levels
  p_reset_idle_r10: assert property (@(posedge clk)
    rst |=> (out_pos == {PHASES{~$past(pol_pos)}} &&
             out_neg == {PHASES{~$past(pol_neg)}}));

  // R6: no leg ever has both sides active
  for (genvar p = 0; p < PHASES; p++) begin : g_ov
    p_no_overlap_r6: assert property (@(posedge clk) disable iff (rst)
      !((out_pos[p] == $past(pol_pos)) && (out_neg[p] == $past(pol_neg))));
  end
endmodule

bind pwm3_comp pwm3_comp_chk #(.W(W), .PHASES(PHASES), .SEL_W(SEL_W)) u_chk (
  .clk(clk), .rst(rst), .run(run), .xfer_mode(xfer_mode),
  .dead_time(dead_time), .pol_pos(pol_pos), .pol_neg(pol_neg),
  .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
  .cnt(cnt), .cmp(cmp_q), .out_pos(out_pos), .out_neg(out_neg)
);

// File: tb/pwm3_comp_test.sv
module pwm3_comp_test;
  localparam int CLK_PERIOD = 10;
  localparam int SAT        = 65535;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        run = 1'b0;
  logic [1:0]  xfer_mode = 2'b11;
  logic [15:0] period_top = 16'd40;
  logic [15:0] dead_time = 16'd3;
  logic        pol_pos = 1'b1;
  logic        pol_neg = 1'b1;
  logic        wr_en = 1'b0;
  logic [2:0]  wr_addr = 3'd0;
  logic [15:0] wr_data = 16'd0;
  logic [2:0]  out_pos, out_neg;

  pwm3_comp uut (
    .clk(clk), .rst(rst), .run(run), .xfer_mode(xfer_mode),
    .period_top(period_top), .dead_time(dead_time),
    .pol_pos(pol_pos), .pol_neg(pol_neg),
    .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .out_pos(out_pos), .out_neg(out_neg)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  int n_chk = 0, n_fail = 0, cyc = 0;
  string cur_tag = "R10";

  // reference model state
  int m_cnt, m_up;
  int m_cmp[3], m_stg[3], m_side[3], m_age[3];
  bit e_p[3], e_n[3];
  bit s_run, s_pp, s_pn;
  int s_td;

  task automatic check(string tag, int act, int exp, string what);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s %s: got %0d expected %0d", tag, what, act, exp);
    end
  endtask

  task automatic model_step();
    bit crest, trough, xfer, raw, ok;
    s_run = run; s_td = dead_time; s_pp = pol_pos; s_pn = pol_neg;
    if (rst) begin
      m_cnt = dead_time; m_up = 1;
      for (int i = 0; i < 3; i++) begin
        m_cmp[i] = 0; m_stg[i] = 0; m_side[i] = 0; m_age[i] = 0;
        e_p[i] = !pol_pos; e_n[i] = !pol_neg;
      end
      return;
    end
    for (int i = 0; i < 3; i++) begin
      if (!run) begin
        m_side[i] = (m_cmp[i] == 0);
        m_age[i]  = (m_cmp[i] == 0 || m_cmp[i] > dead_time) ? SAT : 0;
      end else begin
        raw = (m_cnt > m_cmp[i]);
        if (raw != m_side[i]) begin m_side[i] = raw; m_age[i] = 0; end
        else if (m_age[i] < SAT) m_age[i]++;
      end
      ok = (m_age[i] >= dead_time);
      e_p[i] = pol_pos ? (m_side[i] && ok) : !(m_side[i] && ok);
      e_n[i] = pol_neg ? (!m_side[i] && ok) : !(!m_side[i] && ok);
    end
    crest  = run && m_up == 1 && m_cnt >= period_top;
    trough = run && m_up == 0 && m_cnt <= dead_time;
    if (!run) begin m_cnt = dead_time; m_up = 1; end
    else if (crest) begin m_up = 0; m_cnt--; end
    else if (trough) begin m_up = 1; m_cnt++; end
    else if (m_up == 1) m_cnt++;
    else m_cnt--;
    xfer = (xfer_mode == 2'b00 && crest) || (xfer_mode == 2'b01 && trough) ||
           (xfer_mode == 2'b10 && (crest || trough));
    for (int i = 0; i < 3; i++) begin
      if (wr_en && wr_addr == 3'(4 + i)) begin
        m_cmp[i] = wr_data; m_stg[i] = wr_data;
      end else begin
        if (xfer) m_cmp[i] = m_stg[i];
        if (wr_en && wr_addr == 3'(i)) m_stg[i] = wr_data;
      end
    end
  endtask

  always @(posedge clk) model_step();

  // gap tracking from the pins
  int off_p[3] = '{-1, -1, -1}, off_n[3] = '{-1, -1, -1};
  bit pa_prev[3], na_prev[3];

  always @(negedge clk) begin
    cyc++;
    for (int i = 0; i < 3; i++) begin
      bit ap, an;
      check(cur_tag, out_pos[i], e_p[i], $sformatf("out_pos[%0d]", i));
      check(cur_tag, out_neg[i], e_n[i], $sformatf("out_neg[%0d]", i));
      ap = (out_pos[i] == s_pp);
      an = (out_neg[i] == s_pn);
      check("R6", int'(ap && an), 0, $sformatf("overlap leg %0d", i));
      if (!s_run || rst) begin
        off_p[i] = -1; off_n[i] = -1;
      end else begin
        if (pa_prev[i] && !ap) off_p[i] = cyc;
        if (na_prev[i] && !an) off_n[i] = cyc;
        if (!na_prev[i] && an && off_p[i] >= 0) begin
          check("R7", cyc - off_p[i], s_td, $sformatf("gap p->n leg %0d", i));
          off_p[i] = -1;
        end
        if (!pa_prev[i] && ap && off_n[i] >= 0) begin
          check("R7", cyc - off_n[i], s_td, $sformatf("gap n->p leg %0d", i));
          off_n[i] = -1;
        end
      end
      pa_prev[i] = ap; na_prev[i] = an;
    end
    if (cyc > 20000) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog: got %0d cycles expected under 20000", cyc);
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end

  task automatic wr(input logic [2:0] a, input int v);
    @(negedge clk);
    wr_en = 1'b1; wr_addr = a; wr_data = 16'(v);
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic wait_cyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  initial begin
    wait_cyc(3);
    check("R10", out_pos, 0, "out_pos in reset");
    check("R10", out_neg, 0, "out_neg in reset");
    rst = 1'b0;

    // R8: start-up table, dead_time = 3
    cur_tag = "R8";
    wr(3'd4, 0); wr(3'd5, 2); wr(3'd6, 20);
    wait_cyc(2);
    check("R8", out_pos, 3'b001, "idle pos, cmp 0/2/20");
    check("R8", out_neg, 3'b100, "idle neg, cmp 0/2/20");
    wr(3'd5, 3); wait_cyc(2);
    check("R8", out_neg, 3'b100, "idle neg, V cmp = td");
    wr(3'd5, 4); wait_cyc(2);
    check("R8", out_neg, 3'b110, "idle neg, V cmp = td+1");

    // R9: inverted levels while idle
    cur_tag = "R9";
    @(negedge clk); pol_pos = 1'b0; pol_neg = 1'b0;
    wait_cyc(2);
    check("R9", out_pos, 3'b110, "inverted idle pos");
    check("R9", out_neg, 3'b001, "inverted idle neg");
    pol_pos = 1'b1; pol_neg = 1'b1;

    // R5: run with fixed compares
    cur_tag = "R5";
    wr(3'd4, 10); wr(3'd5, 20); wr(3'd6, 30);
    @(negedge clk); run = 1'b1;
    wait_cyc(230);

    // R1: new top and dead time
    cur_tag = "R1";
    @(negedge clk); run = 1'b0;
    wait_cyc(3);
    period_top = 16'd30; dead_time = 16'd2; run = 1'b1;
    wait_cyc(150);

    // R2 / R3: staged writes under each mode
    cur_tag = "R2";
    xfer_mode = 2'b11;
    wr(3'd0, 25); wr(3'd1, 12);
    wait_cyc(150);
    cur_tag = "R3";
    xfer_mode = 2'b00; wr(3'd0, 25); wait_cyc(120);
    xfer_mode = 2'b01; wr(3'd1, 12); wait_cyc(120);
    xfer_mode = 2'b10; wr(3'd2, 15); wr(3'd0, 8); wait_cyc(120);

    // R4: immediate load while running
    cur_tag = "R4";
    xfer_mode = 2'b11;
    wr(3'd4, 18); wait_cyc(40); wr(3'd6, 22); wait_cyc(80);

    // R11: writes to the unused leg field
    cur_tag = "R11";
    xfer_mode = 2'b10;
    wr(3'd3, 5); wr(3'd7, 6); wait_cyc(120);

    // R9: active-low positive side while running
    cur_tag = "R9";
    pol_pos = 1'b0; wait_cyc(120);

    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule